// File: doc/BRIEF.md
# Nine-Bit Multidrop Serial Port

This block is an asynchronous serial receiver and transmitter for nine-bit frames on a shared multidrop line. The ninth data bit tells address frames apart from data frames. Every node on the bus can wait for address frames while it discards data traffic. Software on each node reads the address frame that arrives, decides whether the address is its own, and releases its receive block so that the following data frames are stored. The block has no hardware address comparator.

A frame is one low start bit, then nine data bits sent least significant bit first, then one high stop bit. Every bit lasts `OSR` baud ticks. A fixed divider produces one tick every `DIV` clock cycles. The receiver samples each bit near its middle. On the transmit side, an eight-bit write takes its ninth bit from a configured default value, so a node only has to supply the ninth bit itself when it sends an address frame. A nine-bit write sends all nine bits exactly as written.

Top module: `mdrop_uart`

## Requirements
- R1: After reset, `txd` is 1, `tx_oe` and `tx_busy` are 0, all three flags are 0, and `rx_data` is 0.
- R2: The line format is a low start bit, nine data bits with the LSB first, and a high stop bit. Each bit lasts `OSR`×`DIV` clocks. The receiver decodes frames sent in this format, and the transmitter produces them.
- R3: When the receive block is low, a frame that is not an address frame and has a good stop bit is written to `rx_data`, and `rx_valid` is set.
- R4: When `cfg_mp_en` is 1, a frame whose ninth bit (`rx_data[8]`) equals `cfg_addr_pol` is an address frame. An address frame is written to `rx_data` and sets both `rx_addr_flag` and `rx_valid`, even while `rx_block` is 1.
- R5: While `rx_block` is 1, a frame that is not an address frame is discarded. `rx_data` keeps its value and `rx_valid` is not set.
- R6: When `cfg_mp_en` is 0, no frame is treated as an address frame, and `rx_addr_flag` is never set.
- R7: When `rx_en` is 0, the receiver ignores the line. No flag is set and `rx_data` does not change.
- R8: A stop bit sampled low sets `rx_ferr_flag`. The frame is then dropped: `rx_data` is unchanged and `rx_valid` is not set.
- R9: The receiver reads `rx_block` only when it samples the stop bit. If the block is released during the data bits of a frame, that frame is stored.
- R10: A pulse on `tx_wr8` sends `{cfg_tx_msb, tx_wdata[7:0]}`. A pulse on `tx_wr9` sends `tx_wdata[8:0]`.
- R11: `tx_oe` and `tx_busy` are 1 for the whole of a frame being sent and 0 otherwise. `txd` is 1 when the transmitter is idle. A write made while the transmitter is busy is ignored.
- R12: The flags stay set until they are cleared. Writing 1 to a bit of `flag_clr` clears one flag: bit 0 clears `rx_valid`, bit 1 clears `rx_addr_flag`, and bit 2 clears `rx_ferr_flag`. If a flag is set and cleared in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mp_en | input | 1 | Enables multidrop address detection |
| cfg_addr_pol | input | 1 | Ninth-bit value that marks an address frame |
| cfg_tx_msb | input | 1 | Ninth bit used for eight-bit transmit writes |
| rx_en | input | 1 | Receiver enable |
| rx_block | input | 1 | Discards frames that are not address frames |
| rxd | input | 1 | Serial receive line (asynchronous) |
| rx_data | output | NBITS | Last frame stored |
| rx_valid | output | 1 | Sticky: a frame was stored |
| rx_addr_flag | output | 1 | Sticky: an address frame was stored |
| rx_ferr_flag | output | 1 | Sticky: a stop bit was sampled low |
| flag_clr | input | 3 | Write-one-to-clear pulses for the flags |
| tx_wr8 | input | 1 | Eight-bit transmit write strobe |
| tx_wr9 | input | 1 | Full-width transmit write strobe |
| tx_wdata | input | NBITS | Transmit data |
| txd | output | 1 | Serial transmit line |
| tx_oe | output | 1 | Transmit driver enable |
| tx_busy | output | 1 | A frame is being sent |

## Verification
The bench builds the block with `NBITS`=9, `OSR`=8 and `DIV`=3, so one bit lasts 24 clocks and a full frame fits in a few hundred cycles. With a bit that short, the bench can run many frames, and it can place a release of the receive block inside the ninth data bit, before the stop bit is sampled. It can also shorten a low stop bit so that the framing error is seen and the line still recovers. The bench drives the receiver directly with frames it forms itself, and it also loops the transmitter back into the receiver so that the ninth-bit fill and the busy behaviour of the transmitter are checked through received data.

// File: rtl/mdrop_pkg.sv
package mdrop_pkg;
   typedef enum logic [1:0] {
      RXS_IDLE,
      RXS_START,
      RXS_DATA,
      RXS_STOP
   } rx_state_e;

   localparam int unsigned FLG_VALID = 0;
   localparam int unsigned FLG_ADDR  = 1;
   localparam int unsigned FLG_FERR  = 2;
   localparam int unsigned FLG_N     = 3;
endpackage

// File: rtl/mdrop_baud.sv
module mdrop_baud #(
   parameter int unsigned DIV = 16
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   generate
      if (DIV == 1) begin : g_direct
         assign tick = 1'b1;
      end else begin : g_count
         localparam int unsigned DW = $clog2(DIV);
         logic [DW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt <= '0;
            end else if (cnt == DW'(DIV - 1)) begin
               cnt <= '0;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
         assign tick = (cnt == DW'(DIV - 1));
      end
   endgenerate
endmodule

// File: rtl/mdrop_rx_deser.sv
module mdrop_rx_deser
   import mdrop_pkg::*;
#(
   parameter int unsigned NBITS = 9,
   parameter int unsigned OSR   = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             rx_en,
   input  logic             rxd,
   output logic             done,
   output logic [NBITS-1:0] bits,
   output logic             stop_ok
);
   localparam int unsigned CW   = $clog2(OSR);
   localparam int unsigned IW   = (NBITS > 1) ? $clog2(NBITS) : 1;
   localparam int unsigned HALF = OSR / 2;

   logic [1:0]       sync_q;
   logic             line;
   rx_state_e        st;
   logic [CW-1:0]    cnt;
   logic [IW-1:0]    idx;
   logic [NBITS-1:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= 2'b11;
      else        sync_q <= {sync_q[0], rxd};
   end
   assign line = sync_q[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= RXS_IDLE;
         cnt     <= '0;
         idx     <= '0;
         sh      <= '0;
         done    <= 1'b0;
         stop_ok <= 1'b1;
      end else if (!rx_en) begin
         st   <= RXS_IDLE;
         done <= 1'b0;
      end else begin
         done <= 1'b0;
         if (tick) begin
            case (st)
               RXS_IDLE: begin
                  if (!line) begin
                     st  <= RXS_START;
                     cnt <= '0;
                  end
               end
               RXS_START: begin
                  if (cnt == CW'(HALF - 1)) begin
                     cnt <= '0;
                     idx <= '0;
                     st  <= line ? RXS_IDLE : RXS_DATA;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               RXS_DATA: begin
                  if (cnt == CW'(OSR - 1)) begin
                     cnt <= '0;
                     sh  <= {line, sh[NBITS-1:1]};
                     if (idx == IW'(NBITS - 1)) st <= RXS_STOP;
                     else                       idx <= idx + 1'b1;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               RXS_STOP: begin
                  if (cnt == CW'(OSR - 1)) begin
                     cnt     <= '0;
                     done    <= 1'b1;
                     stop_ok <= line;
                     st      <= RXS_IDLE;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               default: st <= RXS_IDLE;
            endcase
         end
      end
   end
   assign bits = sh;

   // R7
   rx_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en |=> !done);
endmodule

// File: rtl/mdrop_rx_filter.sv
module mdrop_rx_filter
   import mdrop_pkg::*;
#(
   parameter int unsigned NBITS = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             done,
   input  logic [NBITS-1:0] bits,
   input  logic             stop_ok,
   input  logic             cfg_mp_en,
   input  logic             cfg_addr_pol,
   input  logic             rx_block,
   input  logic [FLG_N-1:0] flag_clr,
   output logic [NBITS-1:0] rx_data,
   output logic             rx_valid,
   output logic             rx_addr_flag,
   output logic             rx_ferr_flag
);
   logic             is_addr;
   logic             good;
   logic             store;
   logic [FLG_N-1:0] set_vec;
   logic [FLG_N-1:0] flags;

   assign is_addr = cfg_mp_en && (bits[NBITS-1] == cfg_addr_pol);
   assign good    = done && stop_ok;
   assign store   = good && (is_addr || !rx_block);

   assign set_vec[FLG_VALID] = store;
   assign set_vec[FLG_ADDR]  = good && is_addr;
   assign set_vec[FLG_FERR]  = done && !stop_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rx_data <= '0;
      else if (store) rx_data <= bits;
   end

   generate
      for (genvar g = 0; g < FLG_N; g++) begin : g_flag
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= 1'b0;
            else        q <= set_vec[g] | (q & ~flag_clr[g]);
         end
         assign flags[g] = q;
      end
   endgenerate

   assign rx_valid     = flags[FLG_VALID];
   assign rx_addr_flag = flags[FLG_ADDR];
   assign rx_ferr_flag = flags[FLG_FERR];

   // R4
   addr_stored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_addr_flag) |-> rx_valid);
   // R5
   blocked_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && rx_block && !is_addr) |=> $stable(rx_data));
   // R6
   no_addr_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_mp_en && !rx_addr_flag) |=> !rx_addr_flag);
   // R8
   ferr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_ferr_flag) |-> $stable(rx_data));
   // R12
   clear_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr[FLG_VALID] && !store) |=> !rx_valid);
endmodule

// File: rtl/mdrop_tx.sv
module mdrop_tx #(
   parameter int unsigned NBITS = 9,
   parameter int unsigned OSR   = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             wr8,
   input  logic             wr9,
   input  logic [NBITS-1:0] wdata,
   input  logic             dflt_msb,
   output logic             txd,
   output logic             tx_oe,
   output logic             busy
);
   localparam int unsigned FW = NBITS + 2;
   localparam int unsigned CW = $clog2(OSR);
   localparam int unsigned BW = $clog2(FW);

   logic [FW-1:0]    sh;
   logic [CW-1:0]    cnt;
   logic [BW-1:0]    bitn;
   logic [NBITS-1:0] frame;

   assign frame = wr9 ? wdata : {dflt_msb, wdata[NBITS-2:0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh   <= '1;
         cnt  <= '0;
         bitn <= '0;
         busy <= 1'b0;
      end else if (!busy) begin
         if (wr8 || wr9) begin
            sh   <= {1'b1, frame, 1'b0};
            cnt  <= '0;
            bitn <= '0;
            busy <= 1'b1;
         end
      end else if (tick) begin
         if (cnt == CW'(OSR - 1)) begin
            cnt <= '0;
            sh  <= {1'b1, sh[FW-1:1]};
            if (bitn == BW'(FW - 1)) busy <= 1'b0;
            else                     bitn <= bitn + 1'b1;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   assign txd   = busy ? sh[0] : 1'b1;
   assign tx_oe = busy;

   // R2
   start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !txd);
   // R2
   stop_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(txd));
   // R11
   busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && (wr8 || wr9) && !tick) |=> (busy && $stable(sh)));
endmodule

// File: rtl/mdrop_uart.sv
module mdrop_uart
   import mdrop_pkg::*;
#(
   parameter int unsigned NBITS = 9,
   parameter int unsigned OSR   = 16,
   parameter int unsigned DIV   = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_mp_en,
   input  logic             cfg_addr_pol,
   input  logic             cfg_tx_msb,
   input  logic             rx_en,
   input  logic             rx_block,
   input  logic             rxd,
   output logic [NBITS-1:0] rx_data,
   output logic             rx_valid,
   output logic             rx_addr_flag,
   output logic             rx_ferr_flag,
   input  logic [2:0]       flag_clr,
   input  logic             tx_wr8,
   input  logic             tx_wr9,
   input  logic [NBITS-1:0] tx_wdata,
   output logic             txd,
   output logic             tx_oe,
   output logic             tx_busy
);
   generate
      if (NBITS < 2) begin : g_bad_nbits
         $error("mdrop_uart: NBITS must be at least 2");
      end
      if (OSR < 4 || (OSR % 2) != 0) begin : g_bad_osr
         $error("mdrop_uart: OSR must be even and at least 4");
      end
      if (DIV < 1) begin : g_bad_div
         $error("mdrop_uart: DIV must be at least 1");
      end
   endgenerate

   logic             tick;
   logic             fr_done;
   logic [NBITS-1:0] fr_bits;
   logic             fr_stop_ok;

   mdrop_baud #(.DIV(DIV)) u_baud (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick)
   );

   mdrop_rx_deser #(.NBITS(NBITS), .OSR(OSR)) u_deser (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .rx_en   (rx_en),
      .rxd     (rxd),
      .done    (fr_done),
      .bits    (fr_bits),
      .stop_ok (fr_stop_ok)
   );

   mdrop_rx_filter #(.NBITS(NBITS)) u_filter (
      .clk          (clk),
      .rst_n        (rst_n),
      .done         (fr_done),
      .bits         (fr_bits),
      .stop_ok      (fr_stop_ok),
      .cfg_mp_en    (cfg_mp_en),
      .cfg_addr_pol (cfg_addr_pol),
      .rx_block     (rx_block),
      .flag_clr     (flag_clr),
      .rx_data      (rx_data),
      .rx_valid     (rx_valid),
      .rx_addr_flag (rx_addr_flag),
      .rx_ferr_flag (rx_ferr_flag)
   );

   mdrop_tx #(.NBITS(NBITS), .OSR(OSR)) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .wr8      (tx_wr8),
      .wr9      (tx_wr9),
      .wdata    (tx_wdata),
      .dflt_msb (cfg_tx_msb),
      .txd      (txd),
      .tx_oe    (tx_oe),
      .busy     (tx_busy)
   );

   // R11
   idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_oe |-> txd);
endmodule

// File: tb/mdrop_uart_test.sv
module mdrop_uart_test;
   localparam int CLK_PERIOD = 10;
   localparam int NB  = 9;
   localparam int OS  = 8;
   localparam int DV  = 3;
   localparam int BIT = OS * DV;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_mp_en = 1'b0, cfg_addr_pol = 1'b1, cfg_tx_msb = 1'b0;
   logic          rx_en = 1'b1, rx_block = 1'b0;
   logic          drv = 1'b1, loop_sel = 1'b0;
   logic [2:0]    flag_clr = 3'b000;
   logic          tx_wr8 = 1'b0, tx_wr9 = 1'b0;
   logic [NB-1:0] tx_wdata = '0;
   logic [NB-1:0] rx_data;
   logic          rx_valid, rx_addr_flag, rx_ferr_flag;
   logic          txd, tx_oe, tx_busy;
   logic          rxd_w;

   int n_chk = 0;
   int n_fail = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   assign rxd_w = loop_sel ? (tx_oe ? txd : 1'b1) : drv;

   mdrop_uart #(.NBITS(NB), .OSR(OS), .DIV(DV)) uut (
      .clk(clk), .rst_n(rst_n),
      .cfg_mp_en(cfg_mp_en), .cfg_addr_pol(cfg_addr_pol), .cfg_tx_msb(cfg_tx_msb),
      .rx_en(rx_en), .rx_block(rx_block), .rxd(rxd_w),
      .rx_data(rx_data), .rx_valid(rx_valid), .rx_addr_flag(rx_addr_flag),
      .rx_ferr_flag(rx_ferr_flag), .flag_clr(flag_clr),
      .tx_wr8(tx_wr8), .tx_wr9(tx_wr9), .tx_wdata(tx_wdata),
      .txd(txd), .tx_oe(tx_oe), .tx_busy(tx_busy)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   task automatic send_frame(input logic [8:0] v, input logic stop_val,
                             input int stop_len, input int unblock_at);
      @(negedge clk);
      drv = 1'b0;
      repeat (BIT) @(negedge clk);
      for (int i = 0; i < 9; i++) begin
         if (i == unblock_at) rx_block = 1'b0;
         drv = v[i];
         repeat (BIT) @(negedge clk);
      end
      drv = stop_val;
      repeat (stop_len) @(negedge clk);
      drv = 1'b1;
      repeat (2 * BIT) @(negedge clk);
   endtask

   task automatic clear_flags(input logic [2:0] m);
      @(negedge clk);
      flag_clr = m;
      @(negedge clk);
      flag_clr = 3'b000;
   endtask

   task automatic t_reset();
      chk("R1 txd", int'(txd), 1);
      chk("R1 tx_oe", int'(tx_oe), 0);
      chk("R1 tx_busy", int'(tx_busy), 0);
      chk("R1 flags", int'({rx_valid, rx_addr_flag, rx_ferr_flag}), 0);
      chk("R1 rx_data", int'(rx_data), 0);
   endtask

   task automatic t_plain();
      cfg_mp_en = 1'b0; rx_block = 1'b0;
      send_frame(9'h0A5, 1'b1, BIT, -1);
      chk("R3 R2 data", int'(rx_data), 'h0A5);
      chk("R3 valid", int'(rx_valid), 1);
      chk("R3 addr", int'(rx_addr_flag), 0);
      clear_flags(3'b111);
      send_frame(9'h15A, 1'b1, BIT, -1);
      chk("R6 data", int'(rx_data), 'h15A);
      chk("R6 addr", int'(rx_addr_flag), 0);
      clear_flags(3'b111);
      rx_block = 1'b1;
      send_frame(9'h1C3, 1'b1, BIT, -1);
      chk("R5 R6 valid", int'(rx_valid), 0);
      chk("R5 R6 addr", int'(rx_addr_flag), 0);
      chk("R5 R6 data", int'(rx_data), 'h15A);
   endtask

   task automatic t_addr();
      cfg_mp_en = 1'b1; cfg_addr_pol = 1'b1; rx_block = 1'b1;
      send_frame(9'h113, 1'b1, BIT, -1);
      chk("R4 data", int'(rx_data), 'h113);
      chk("R4 addr", int'(rx_addr_flag), 1);
      chk("R4 valid", int'(rx_valid), 1);
      clear_flags(3'b111);
      send_frame(9'h044, 1'b1, BIT, -1);
      chk("R5 valid", int'(rx_valid), 0);
      chk("R5 data", int'(rx_data), 'h113);
      cfg_addr_pol = 1'b0;
      send_frame(9'h027, 1'b1, BIT, -1);
      chk("R4 pol0 data", int'(rx_data), 'h027);
      chk("R4 pol0 addr", int'(rx_addr_flag), 1);
      clear_flags(3'b111);
      send_frame(9'h1F0, 1'b1, BIT, -1);
      chk("R5 pol0 valid", int'(rx_valid), 0);
      chk("R5 pol0 data", int'(rx_data), 'h027);
   endtask

   task automatic t_disabled();
      cfg_addr_pol = 1'b1; rx_en = 1'b0;
      send_frame(9'h1AA, 1'b1, BIT, -1);
      chk("R7 flags", int'({rx_valid, rx_addr_flag, rx_ferr_flag}), 0);
      chk("R7 data", int'(rx_data), 'h027);
      rx_en = 1'b1;
   endtask

   task automatic t_ferr();
      rx_block = 1'b0;
      send_frame(9'h0F1, 1'b0, (3 * BIT) / 4, -1);
      chk("R8 ferr", int'(rx_ferr_flag), 1);
      chk("R8 valid", int'(rx_valid), 0);
      chk("R8 data", int'(rx_data), 'h027);
      repeat (4 * BIT) @(negedge clk);
      chk("R12 ferr sticky", int'(rx_ferr_flag), 1);
      clear_flags(3'b100);
      chk("R12 ferr cleared", int'(rx_ferr_flag), 0);
   endtask

   task automatic t_late_unblock();
      cfg_mp_en = 1'b1; cfg_addr_pol = 1'b1; rx_block = 1'b1;
      send_frame(9'h1B0, 1'b1, BIT, -1);
      chk("R9 addr data", int'(rx_data), 'h1B0);
      clear_flags(3'b111);
      send_frame(9'h0D2, 1'b1, BIT, 8);
      chk("R9 late data", int'(rx_data), 'h0D2);
      chk("R9 late valid", int'(rx_valid), 1);
      chk("R9 late addr", int'(rx_addr_flag), 0);
      clear_flags(3'b111);
   endtask

   task automatic t_tx8();
      loop_sel = 1'b1; cfg_mp_en = 1'b0; rx_block = 1'b0; cfg_tx_msb = 1'b1;
      @(negedge clk);
      tx_wdata = 9'h03C; tx_wr8 = 1'b1;
      @(negedge clk);
      tx_wr8 = 1'b0;
      repeat (BIT) @(negedge clk);
      chk("R11 oe during", int'(tx_oe), 1);
      chk("R11 busy during", int'(tx_busy), 1);
      repeat (12 * BIT) @(negedge clk);
      chk("R10 R2 wr8 data", int'(rx_data), 'h13C);
      chk("R11 oe after", int'(tx_oe), 0);
      chk("R11 txd idle", int'(txd), 1);
   endtask

   task automatic t_tx9();
      clear_flags(3'b111);
      @(negedge clk);
      tx_wdata = 9'h066; tx_wr9 = 1'b1;
      @(negedge clk);
      tx_wr9 = 1'b0;
      repeat (3 * BIT) @(negedge clk);
      tx_wdata = 9'h199; tx_wr8 = 1'b1;
      @(negedge clk);
      tx_wr8 = 1'b0;
      repeat (9 * BIT) @(negedge clk);
      chk("R11 no second frame", int'(tx_oe), 0);
      chk("R10 wr9 data", int'(rx_data), 'h066);
      repeat (2 * BIT) @(negedge clk);
      chk("R11 still idle", int'(tx_busy), 0);
      chk("R12 valid sticky", int'(rx_valid), 1);
      clear_flags(3'b001);
      chk("R12 valid cleared", int'(rx_valid), 0);
      loop_sel = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_plain();
      t_addr();
      t_disabled();
      t_ferr();
      t_late_unblock();
      t_tx8();
      t_tx9();
      finish_run();
   end
endmodule